// File: doc/BRIEF.md
# LED Control Register Target on a Two-Wire Serial Bus

This block is the serial-bus front end of a sixteen-channel LED controller. It watches the two bus lines, which are sampled by the system clock, and answers its own 7-bit target address. The first byte written after the address is a command byte. That byte loads a 4-bit register pointer and a flag that selects whether the pointer steps forward after each data byte. Data bytes that follow are written into, or read from, a ten-entry register map. Two entries of the map return the levels of the sixteen LED pins. The other eight are read/write bytes that drive the blink generators and the per-LED mode selectors.

A host normally writes the blink periods, the duty values and the four mode bytes in one burst with stepping enabled. Later it changes single mode bytes with short writes. To read a register, the host writes a command byte, issues a repeated START and reads. The block only ever pulls SDA low or releases it, and it does so only while SCL is low. It never holds SCL low to stretch the clock.

The control path is one state machine with these states:
- IDLE: the bus is free.
- ADDR: the address byte is being shifted in.
- ADDR_ACK: the block acknowledges its address.
- CMD and CMD_ACK: the command byte is received and then acknowledged.
- WDATA and WDATA_ACK: a data byte is received and then acknowledged.
- RDATA: a byte is shifted out.
- RDATA_ACK: the host's acknowledge bit is sampled.
- SKIP: the block ignores the bus until the next START or STOP.

Transitions:
- IDLE→ADDR on START.
- ADDR→ADDR_ACK on an address match, ADDR→SKIP on a mismatch.
- ADDR_ACK→CMD for a write, ADDR_ACK→RDATA for a read.
- CMD→CMD_ACK→WDATA.
- WDATA→WDATA_ACK→WDATA.
- RDATA→RDATA_ACK.
- RDATA_ACK→RDATA when the host acknowledges, RDATA_ACK→SKIP when it does not.
- Any state→ADDR on START, any state→IDLE on STOP.

Top module: `ledreg_i2c_target`

## Requirements
- R1: The address byte is taken MSB first. Its seven upper bits must equal binary 1100 followed by strap[2], strap[1] and strap[0], and its last bit is the direction (1 = read). On a match the block pulls SDA low for the ninth clock. On a mismatch it leaves SDA released until the next START.
- R2: The first byte written after a matching write address is the command byte. Bit 4 is the step flag and bits [3:0] are the pointer. The pointer and flag keep their values across transactions, and both reset to zero.
- R3: Register map, by pointer value:
  - 0 returns pin_lvl[7:0]; 1 returns pin_lvl[15:8].
  - 2 drives blink0_period (reset FFh); 3 drives blink0_duty (reset 80h).
  - 4 drives blink1_period (reset FFh); 5 drives blink1_duty (reset 80h).
  - 6 to 9 drive led_mode[7:0], [15:8], [23:16] and [31:24] (reset 55h each).
- R4: Every data byte written is acknowledged. If the pointer is in 2..9, the byte is stored into the register the pointer selects.
- R5: With the step flag set, the pointer advances after each data byte written or read. A pointer of 9 or more steps to 0; any other value steps by one.
- R6: With the step flag clear, every data byte in the transaction uses the same pointer.
- R7: Writes to pointers 0 and 1 are acknowledged and change no register.
- R8: Pointers 10 to 15 read as 00h. Writes to them are acknowledged and ignored.
- R9: Read data goes out MSB first, and SDA changes only while SCL is low. A host acknowledge brings the next byte. A host non-acknowledge makes the block release SDA until START or STOP.
- R10: A pin byte is sampled at the SCL falling edge that ends the acknowledge before it. Pin changes during the byte do not alter that byte.
- R11: A START at any point restarts address decoding and discards a partly received byte. A STOP returns the block to IDLE.
- R12: While rst_n is low, all registers hold their reset values, the state machine is in IDLE and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| strap | input | 3 | Low three bits of the target address |
| pin_lvl | input | 16 | Levels of the sixteen LED pins |
| sda_pull | output | 1 | 1 = pull SDA low |
| blink0_period | output | 8 | Period byte of blink generator 0 |
| blink0_duty | output | 8 | Duty byte of blink generator 0 |
| blink1_period | output | 8 | Period byte of blink generator 1 |
| blink1_duty | output | 8 | Duty byte of blink generator 1 |
| led_mode | output | 32 | Two mode bits per LED, LED n at [2n+1:2n] |

## Verification
The hardest cases to reach from the ports are the ones that only exist inside a single bus cycle. One is a repeated START that lands after four bits of a data byte. Another is a pin change that happens between the acknowledge edge that loads a byte and the acknowledge edge that loads the next one. The bench bit-bangs both lines with its own master tasks, which makes such cases easy to stage. One task cuts a byte short and then issues a START. The read task can change the pin levels halfway through a byte, so the bench can show that the byte in flight keeps its old value and the next byte picks up the new one. Random bursts with random pointers, step flags and lengths cover the pointer wrap from unmapped and top-of-map positions.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 4;
    localparam int NUM_REG = 10;               // size of the register map
    localparam int NUM_RO  = 2;                // pin-level bytes at the bottom of the map
    localparam int NUM_RW  = NUM_REG - NUM_RO; // stored control bytes
    localparam int PIN_W   = NUM_RO * BYTE_W;
    localparam int NUM_BLINK_BYTES = 4;        // period/duty pairs ahead of the mode bytes
    localparam int MODE_W  = (NUM_RW - NUM_BLINK_BYTES) * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_SKIP
    } bus_state_t;

    // R3: reset value of stored byte idx (pointer = idx + NUM_RO)
    function automatic logic [BYTE_W-1:0] rw_default(input int idx);
        if (idx == 0 || idx == 2) return 8'hFF;
        if (idx == 1 || idx == 3) return 8'h80;
        return 8'h55;
    endfunction

    // R5: pointer step with wrap at the top of the map
    function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
        return (p >= PTR_W'(NUM_REG - 1)) ? '0 : p + PTR_W'(1);
    endfunction
endpackage

// File: rtl/ledreg_line_sync.sv
module ledreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  =  scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl &  scl_d;
    assign start_det =  scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  =  scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ledreg_bank.sv
module ledreg_bank
    import ledreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PTR_W-1:0]         wr_ptr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [PTR_W-1:0]         rd_ptr,
    input  logic [PIN_W-1:0]         pin_lvl,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NUM_RW*BYTE_W-1:0] rw_flat
);
    logic [NUM_RW*BYTE_W-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RW; i++) store_q[i*BYTE_W +: BYTE_W] <= rw_default(i);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_RW; i++)
                if (wr_ptr == PTR_W'(i + NUM_RO)) store_q[i*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    // Read mux: pins live at the bottom, holes above the map read zero (R8, R10)
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RO; i++)
            if (rd_ptr == PTR_W'(i)) rd_data = pin_lvl[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < NUM_RW; i++)
            if (rd_ptr == PTR_W'(i + NUM_RO)) rd_data = store_q[i*BYTE_W +: BYTE_W];
    end

    assign rw_flat = store_q;

    a_r7_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr < PTR_W'(NUM_RO)) |=> $stable(store_q));
    a_r8_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr >= PTR_W'(NUM_REG)) |=> $stable(store_q));
endmodule

// File: rtl/ledreg_i2c_target.sv
module ledreg_i2c_target
    import ledreg_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b1100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    input  logic [PIN_W-1:0]  pin_lvl,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] blink0_period,
    output logic [BYTE_W-1:0] blink0_duty,
    output logic [BYTE_W-1:0] blink1_period,
    output logic [BYTE_W-1:0] blink1_duty,
    output logic [MODE_W-1:0] led_mode
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t state_q, state_nx;
    logic [3:0]              bit_cnt;
    logic [BYTE_W-1:0]       rx_q, tx_q, rd_data;
    logic [PTR_W-1:0]        ptr_q;
    logic                    ai_q, rw_q, mack_q;
    logic                    addr_hit, byte_in_done, wr_en;
    logic [NUM_RW*BYTE_W-1:0] rw_flat;

    ledreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ledreg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr_q), .wr_data(rx_q),
        .rd_ptr(ptr_q), .pin_lvl(pin_lvl), .rd_data(rd_data), .rw_flat(rw_flat)
    );

    assign addr_hit     = (rx_q[7:1] == {ADDR_PREFIX, strap});
    assign byte_in_done = scl_fall && (bit_cnt == 4'd8);
    assign wr_en        = (state_q == ST_WDATA) && byte_in_done && !start_det && !stop_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (stop_det)       state_nx = ST_IDLE;
        else if (start_det) state_nx = ST_ADDR;
        else begin
            unique case (state_q)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_in_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_in_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_in_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_nx = mack_q ? ST_RDATA : ST_SKIP;
                ST_SKIP:      state_nx = ST_SKIP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Shift registers, pointer and command flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            ai_q    <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            case (state_q)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_q    <= {rx_q[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state_q == ST_ADDR) rw_q <= rx_q[0];
                        if (state_q == ST_CMD) begin
                            ptr_q <= rx_q[PTR_W-1:0];
                            ai_q  <= rx_q[4];
                        end
                        if (state_q == ST_WDATA && ai_q) ptr_q <= ptr_advance(ptr_q);
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        tx_q    <= rd_data;     // R10: pins sampled here
                        bit_cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7 && ai_q) ptr_q <= ptr_advance(ptr_q);
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    else if (scl_fall && mack_q) begin
                        tx_q    <= rd_data;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                              sda_pull = ~tx_q[BYTE_W-1];
            default:                               sda_pull = 1'b0;
        endcase
    end

    assign blink0_period = rw_flat[0*BYTE_W +: BYTE_W];
    assign blink0_duty   = rw_flat[1*BYTE_W +: BYTE_W];
    assign blink1_period = rw_flat[2*BYTE_W +: BYTE_W];
    assign blink1_duty   = rw_flat[3*BYTE_W +: BYTE_W];
    assign led_mode      = rw_flat[NUM_RW*BYTE_W-1 : NUM_BLINK_BYTES*BYTE_W];

    a_r9_sda_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_lvl);
    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));
    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && !sda_pull));
    a_r1_released_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP || state_q == ST_IDLE) |-> !sda_pull);
endmodule

// File: tb/ledreg_i2c_target_test.sv
module ledreg_i2c_target_test;
    localparam int Q = 5;
    localparam logic [3:0] PFX = 4'b1100;
    localparam logic [63:0] RST_EXP = 64'hFF80FF8055555555;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, scl_m, sda_m, sda_pull, sda_line;
    logic [2:0]  strap = 3'b101;
    logic [15:0] pins;
    logic [7:0]  b0p, b0d, b1p, b1d;
    logic [31:0] lmode;
    assign sda_line = sda_m & ~sda_pull;

    ledreg_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .strap(strap),
        .pin_lvl(pins), .sda_pull(sda_pull), .blink0_period(b0p), .blink0_duty(b0d),
        .blink1_period(b1p), .blink1_duty(b1d), .led_mode(lmode)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [10];
    logic [3:0] m_ptr;
    logic       m_ai;

    function automatic logic [3:0] nptr(input logic [3:0] p);
        return (p >= 4'd9) ? 4'd0 : p + 4'd1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] p);
        if (p == 4'd0) return pins[7:0];
        if (p == 4'd1) return pins[15:8];
        if (p <= 4'd9) return mdl[p];
        return 8'h00;
    endfunction

    function automatic logic [63:0] exp_exports();
        return {mdl[2], mdl[3], mdl[4], mdl[5], mdl[9], mdl[8], mdl[7], mdl[6]};
    endfunction

    function automatic string wtag(input logic [3:0] p);
        if (p < 4'd2) return "R7 write to pin byte acked";
        if (p > 4'd9) return "R8 write to unmapped acked";
        return "R4 write acked";
    endfunction

    function automatic string rtag(input logic [3:0] p, input logic ai);
        if (p < 4'd2) return "R10 pin byte read";
        if (p > 4'd9) return "R8 unmapped reads 00";
        return ai ? "R5 stepping read" : "R6 fixed-pointer read";
    endfunction

    task automatic model_reset();
        mdl[0] = 8'h00; mdl[1] = 8'h00;
        mdl[2] = 8'hFF; mdl[3] = 8'h80; mdl[4] = 8'hFF; mdl[5] = 8'h80;
        for (int i = 6; i < 10; i++) mdl[i] = 8'h55;
        m_ptr = 4'd0; m_ai = 1'b0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, input logic chg, input logic [15:0] np,
                             output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            d[i] = sda_line;
            if (chg && i == 4) pins = np;
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic addr_cmd(input logic [3:0] p, input logic ai);
        logic a;
        send_byte({PFX, strap, 1'b0}, a); check("R1 write address acked", a, 1);
        send_byte({3'b000, ai, p}, a);    check("R2 command byte acked", a, 1);
        m_ptr = p; m_ai = ai;
    endtask

    task automatic wr_txn(input logic [3:0] p, input logic ai, input int n);
        logic a; logic [7:0] d;
        bus_start(); addr_cmd(p, ai);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a); check(wtag(m_ptr), a, 1);
            if (m_ptr >= 4'd2 && m_ptr <= 4'd9) mdl[m_ptr] = d;
            if (m_ai) m_ptr = nptr(m_ptr);
        end
        bus_stop();
        check("R4 exported bytes follow writes", {b0p, b0d, b1p, b1d, lmode}, exp_exports());
    endtask

    task automatic rd_bytes(input int n);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, 1'b0, 16'h0, d);
            check(rtag(m_ptr, m_ai), d, exp_rd(m_ptr));
            if (m_ai) m_ptr = nptr(m_ptr);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [3:0] p, input logic ai, input int n);
        logic a;
        bus_start(); addr_cmd(p, ai);
        bus_start(); send_byte({PFX, strap, 1'b1}, a); check("R1 read address acked", a, 1);
        rd_bytes(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a; logic [7:0] d;
        void'($urandom(32'd7031));
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pins = 16'hA5C3;
        model_reset();
        tick(5);
        check("R12 SDA released in reset", sda_pull, 0);
        check("R3 reset values on outputs", {b0p, b0d, b1p, b1d, lmode}, RST_EXP);
        rst_n = 1'b1; tick(4);

        // R3: whole map after reset, stepping from 0
        rd_txn(4'd0, 1'b1, 10);

        // R1: wrong strap bits and wrong prefix get no acknowledge
        bus_start(); send_byte({PFX, strap ^ 3'b001, 1'b0}, a); check("R1 strap mismatch not acked", a, 0);
        send_byte(8'h00, a); check("R1 silent after mismatch", a, 0); bus_stop();
        bus_start(); send_byte({4'b1101, strap, 1'b0}, a); check("R1 prefix mismatch not acked", a, 0);
        bus_stop();

        // R5: burst across the top of the map and wrap
        wr_txn(4'd2, 1'b1, 11);
        rd_txn(4'd8, 1'b1, 12);

        // R6: fixed pointer
        wr_txn(4'd3, 1'b0, 3);
        rd_txn(4'd3, 1'b0, 3);

        // R7 and R8: pin bytes and unmapped pointers
        wr_txn(4'd0, 1'b0, 2);
        wr_txn(4'd12, 1'b0, 2);
        rd_txn(4'd13, 1'b0, 2);
        rd_txn(4'd11, 1'b1, 3);

        // R9: host non-acknowledge releases the line; R2: pointer persists
        wr_txn(4'd6, 1'b1, 0);
        bus_start(); send_byte({PFX, strap, 1'b1}, a); check("R1 read address acked", a, 1);
        recv_byte(1'b0, 1'b0, 16'h0, d); check("R9 byte before NACK", d, mdl[6]);
        m_ptr = nptr(m_ptr);
        recv_byte(1'b0, 1'b0, 16'h0, d); check("R9 SDA released after NACK", d, 8'hFF);
        check("R9 no pull after NACK", sda_pull, 0);
        bus_stop();
        bus_start(); send_byte({PFX, strap, 1'b1}, a); check("R1 read address acked", a, 1);
        recv_byte(1'b0, 1'b0, 16'h0, d); check("R2 pointer kept across transactions", d, mdl[7]);
        m_ptr = nptr(m_ptr);
        bus_stop();

        // R10: pin bytes are captured at the acknowledge falling edge
        pins = 16'h3C5A;
        wr_txn(4'd0, 1'b0, 0);
        bus_start(); send_byte({PFX, strap, 1'b1}, a); check("R1 read address acked", a, 1);
        recv_byte(1'b1, 1'b1, 16'h96E1, d); check("R10 byte keeps earlier sample", d, 8'h5A);
        recv_byte(1'b0, 1'b0, 16'h0, d);    check("R10 next byte takes new pins", d, 8'hE1);
        bus_stop();

        // R11: repeated START after half a data byte
        bus_start(); addr_cmd(4'd3, 1'b0);
        send_bits(8'h0F, 4);
        bus_start(); send_byte({PFX, strap, 1'b1}, a); check("R11 address after restart acked", a, 1);
        recv_byte(1'b0, 1'b0, 16'h0, d); check("R11 partial byte discarded", d, mdl[3]);
        bus_stop();

        // R12: reset in the middle of a write burst
        bus_start(); addr_cmd(4'd6, 1'b1);
        send_byte(8'h00, a); check("R4 write acked", a, 1);
        mdl[6] = 8'h00;
        check("R4 mode byte written", lmode[7:0], 8'h00);
        send_bits(8'h00, 2);
        rst_n = 1'b0; tick(3);
        check("R12 SDA released in reset", sda_pull, 0);
        check("R12 registers at reset values", {b0p, b0d, b1p, b1d, lmode}, RST_EXP);
        scl_m = 1'b1; sda_m = 1'b1; tick(4*Q);
        rst_n = 1'b1; tick(4);
        model_reset();
        rd_txn(4'd6, 1'b0, 1);

        // Random bursts
        for (int it = 0; it < 30; it++) begin
            logic [3:0] p; logic ai; int n;
            pins = 16'($urandom);
            p  = 4'($urandom_range(0, 15));
            ai = 1'($urandom_range(0, 1));
            n  = $urandom_range(1, 4);
            wr_txn(p, ai, n);
            rd_txn(p, ai, n);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule